// File: doc/BRIEF.md
# Flash Command and Interrupt Register Controller

This block is the host-facing register file of a flash-style storage controller. A simple host bus writes and reads 16-bit registers: a command register, two system configuration registers, a start-buffer register, a bank of start-address registers, a controller status register and an interrupt status register. When the host writes a command code, the block checks it and sends a one-cycle strobe carrying the code to the execution units. Those units report back with a completion pulse that says which kind of work finished and whether it failed.

The interrupt status register holds one done flag per kind of work and a summary bit (bit 15). The summary bit drives an interrupt pin whose polarity is set by software. The host clears flags by writing a mask that is ANDed into the register. Once the summary bit is clear, the error flags in the controller status register are wiped as well. No new command is accepted while the summary bit is set, so software must acknowledge each completion before it issues the next command.

The read port is combinational from `host_addr`. Every write takes effect at the clock edge on which `host_wr` is sampled high. Strobes and status changes appear in the cycle after that edge.

Top module: `flcr_regblock`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge) the registers hold these values: configuration-1 (offset 0x01) 0x40C0, configuration-2 (0x02) 0x0000, interrupt status (0x05) 0x8080, controller status (0x04) 0x0000, command (0x00) 0x0000, start-buffer buffer field 0 with sector count 1, and all start-address registers 0.
- R2: A write of a recognised code to the command register (offset 0x00) while interrupt bit 15 is clear does three things. It stores the value, it raises `cmd_go` for exactly one cycle in the next cycle, and it places the low byte on `cmd_code`. The recognised codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x94, 0x95, 0xB0, 0xF0 and 0xF3, each with upper byte zero.
- R3: A command write made while interrupt status bit 15 is set is ignored: the command register keeps its value, no strobe is issued and the status registers are unchanged.
- R4: An accepted command value that is not recognised sets controller status bit 10 and interrupt status bit 15, and issues no strobe.
- R5: A pulse on `done_valid` sets interrupt bit 15 together with a done bit chosen by `done_kind`: 0 (reset) sets bit 4, 1 (erase) sets bit 5, 2 (program) sets bit 6 and 3 (load) sets bit 7.
- R6: A completion pulse with `done_err` high sets controller status bit 10 and a specific error bit: bit 11 for erase, bit 12 for program, bit 13 for load, and no specific bit for reset.
- R7: A write to the interrupt register (offset 0x05) replaces its value with the old value ANDed with the written data. If bit 15 of the result is clear, controller status bits 13:10 are cleared.
- R8: When an interrupt-register write and a completion pulse fall in the same cycle, the bits set by the completion survive the mask. Because bit 15 then ends up set, the error bits are not cleared, and any new error bits are added to them.
- R9: `irq` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6. `rdy` equals configuration-1 bit 7.
- R10: A configuration-1 read returns the stored value with bits 4:0 forced to zero. Configuration-2 reads back all 16 written bits.
- R11: A start-buffer write (offset 0x03) stores bits 11:8 as the buffer select and bits 1:0 as the sector count, where 0 means 4. A read returns the buffer select in bits 11:8 and the count modulo 4 in bits 1:0, with zeros elsewhere. `buf_sel` and `sec_count` show the stored fields.
- R12: An accepted command 0xF3 is a hot reset. It restores every R1 value except that interrupt status becomes 0x8010 and the command register keeps 0x00F3. It issues no strobe.
- R13: The start-address registers sit at offsets 0x10 onward, one per index. Each stores and reads back a full 16-bit word, and all of them appear on `start_addr_flat`, with register n in bits 16n+15:16n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| host_wr | input | 1 | Register write enable for this cycle |
| host_addr | input | ADDR_W (8) | Register word offset for read and write |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for `host_addr` (combinational) |
| cmd_go | output | 1 | One-cycle command strobe to the execution units |
| cmd_code | output | 8 | Code of the last issued command |
| buf_sel | output | 4 | Stored buffer select |
| sec_count | output | 3 | Stored sector count, 1 to 4 |
| start_addr_flat | output | NUM_ADDR*16 (128) | All start-address registers, packed |
| done_valid | input | 1 | Completion report pulse |
| done_kind | input | 2 | Kind of completed work (0 reset, 1 erase, 2 program, 3 load) |
| done_err | input | 1 | Completion ended in an error |
| irq | output | 1 | Interrupt pin, polarity per configuration-1 bit 6 |
| rdy | output | 1 | Ready pin, follows configuration-1 bit 7 |

## Verification
The assertions assume a single bus, so at most one register write can occur per cycle. In particular, a command write and an interrupt-register write never coincide. They also assume that `done_kind` and `done_err` are meaningful only while `done_valid` is high. The directed stimulus issues each write as a single-cycle pulse and drives completion pulses for one cycle only. It combines a completion with a bus write only in the deliberate same-cycle priority scenario, and that write targets the interrupt register, never the command register.

// File: rtl/flcr_pkg.sv
// Package: shared register offsets, bit positions and command decoding for
// the flash command/interrupt register block. Assumes 16-bit registers.
package flcr_pkg;

    localparam int DW = 16;

    // Register word offsets
    localparam int OFF_CMD    = 'h00;
    localparam int OFF_CFG1   = 'h01;
    localparam int OFF_CFG2   = 'h02;
    localparam int OFF_SBUF   = 'h03;
    localparam int OFF_STAT   = 'h04;
    localparam int OFF_INT    = 'h05;
    localparam int OFF_ADDR0  = 'h10;

    // Interrupt status bits
    localparam int INT_SUM    = 15;
    localparam int INT_RST    = 4;

    // Controller status error bits
    localparam int ERR_CMD    = 10;
    localparam int ERR_ERASE  = 11;
    localparam int ERR_PROG   = 12;
    localparam int ERR_LOAD   = 13;
    localparam logic [DW-1:0] ERR_MASK = 16'h3C00;

    // Reset values
    localparam logic [DW-1:0] CFG1_INIT     = 16'h40C0;
    localparam logic [DW-1:0] INT_COLD_INIT = 16'h8080;
    localparam logic [DW-1:0] INT_HOT_INIT  = 16'h8010;

    localparam logic [DW-1:0] CMD_HOT_RESET = 16'h00F3;

    typedef enum logic [1:0] {
        DK_RESET = 2'd0,
        DK_ERASE = 2'd1,
        DK_PROG  = 2'd2,
        DK_LOAD  = 2'd3
    } done_kind_e;

    // Returns 1 when the 16-bit value is a command code the block accepts
    function automatic logic cmd_known(input logic [DW-1:0] v);
        logic ok;
        if (v[15:8] != 8'h00) begin
            ok = 1'b0;
        end else begin
            case (v[7:0])
                8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A,
                8'h2C, 8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0, 8'hF0,
                8'hF3:   ok = 1'b1;
                default: ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/flcr_cmd_unit.sv
// Command register and strobe generator.
// Accepts a command write only while no interrupt is pending, classifies the
// code, and registers a one-cycle strobe for known codes. Hot reset (0xF3)
// and unknown codes are reported combinationally to the sibling units.
// Assumes at most one host write per cycle.
module flcr_cmd_unit
    import flcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [DW-1:0] wdata,
    input  logic          int_pending,
    output logic [DW-1:0] cmd_q,
    output logic          cmd_go,
    output logic [7:0]    cmd_code,
    output logic          cmd_bad,
    output logic          hot_rst
);

    logic accept;
    logic known;
    logic issue;

    // Classify the incoming command write
    always_comb begin
        accept  = cmd_wr && !int_pending;
        known   = cmd_known(wdata);
        hot_rst = accept && (wdata == CMD_HOT_RESET);
        cmd_bad = accept && !known;
        issue   = accept && known && !hot_rst;
    end

    // Hold the command register and produce the registered strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            cmd_go   <= 1'b0;
            cmd_code <= '0;
        end else begin
            cmd_go <= issue;
            if (accept)
                cmd_q <= wdata;
            if (issue)
                cmd_code <= wdata[7:0];
        end
    end

    // Strobe only follows a write made with the summary bit clear (R3)
    p_refuse_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && int_pending) |=> !cmd_go);

    // Strobe is a single cycle wide after an isolated write (R2)
    p_strobe_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !int_pending && cmd_known(wdata) && wdata != CMD_HOT_RESET)
        |=> (cmd_go && cmd_code == $past(wdata[7:0])));

    // Unknown codes never strobe (R4)
    p_no_strobe_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bad |=> !cmd_go);

endmodule

// File: rtl/flcr_int_unit.sv
// Interrupt status and controller status registers.
// Merges AND-mask clears from the host with completion reports and unknown-
// command flags; set bits win over the mask. Clears error bits whenever the
// resulting summary bit is clear. Assumes done_kind/done_err are only valid
// while done_valid is high.
module flcr_int_unit
    import flcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          int_wr,
    input  logic [DW-1:0] wdata,
    input  logic          done_valid,
    input  logic [1:0]    done_kind,
    input  logic          done_err,
    input  logic          cmd_bad,
    input  logic          hot_rst,
    output logic [DW-1:0] int_q,
    output logic [DW-1:0] stat_q
);

    logic [DW-1:0] done_set;
    logic [DW-1:0] err_set;
    logic [DW-1:0] masked;
    logic [DW-1:0] int_nx;
    logic [DW-1:0] stat_nx;

    // Translate a completion report into interrupt and error bits
    always_comb begin
        done_set = '0;
        err_set  = '0;
        if (done_valid) begin
            done_set[INT_SUM]                  = 1'b1;
            done_set[INT_RST + int'(done_kind)] = 1'b1;
            if (done_err) begin
                err_set[ERR_CMD] = 1'b1;
                case (done_kind_e'(done_kind))
                    DK_ERASE: err_set[ERR_ERASE] = 1'b1;
                    DK_PROG:  err_set[ERR_PROG]  = 1'b1;
                    DK_LOAD:  err_set[ERR_LOAD]  = 1'b1;
                    default:  ;
                endcase
            end
        end
        if (cmd_bad) begin
            done_set[INT_SUM] = 1'b1;
            err_set[ERR_CMD]  = 1'b1;
        end
    end

    // Compute next values: mask first, then OR in set bits
    always_comb begin
        masked  = int_wr ? (int_q & wdata) : int_q;
        int_nx  = masked | done_set;
        stat_nx = (int_nx[INT_SUM] ? stat_q : (stat_q & ~ERR_MASK)) | err_set;
    end

    // Register update with cold and hot reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= INT_COLD_INIT;
            stat_q <= '0;
        end else if (hot_rst) begin
            int_q  <= INT_HOT_INIT;
            stat_q <= '0;
        end else begin
            int_q  <= int_nx;
            stat_q <= stat_nx;
        end
    end

    // Completion always raises the summary bit (R5)
    p_done_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> int_q[INT_SUM]);

    // Failed completion raises the command-error bit (R6)
    p_err_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_err && !hot_rst) |=> stat_q[ERR_CMD]);

    // A clearing write with no completion wipes every error bit (R7)
    p_clear_errs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr && !done_valid && !wdata[INT_SUM]) |=> ((stat_q & ERR_MASK) == '0));

    // Completion bits survive a same-cycle mask write (R8)
    p_done_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr && done_valid) |=> (int_q[INT_SUM] && int_q[INT_RST + int'($past(done_kind))]));

    // Unknown command flags both registers (R4)
    p_bad_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bad |=> (int_q[INT_SUM] && stat_q[ERR_CMD]));

endmodule

// File: rtl/flcr_cfg_unit.sv
// Configuration, start-buffer and start-address registers.
// Plain storage with write enables decoded by the top; all restore their
// defaults on cold or hot reset. Assumes addr_idx < NUM_ADDR when addr_wr.
module flcr_cfg_unit
    import flcr_pkg::*;
#(
    parameter int NUM_ADDR = 8,
    localparam int AIDX_W  = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hot_rst,
    input  logic                   cfg1_wr,
    input  logic                   cfg2_wr,
    input  logic                   sbuf_wr,
    input  logic                   addr_wr,
    input  logic [AIDX_W-1:0]      addr_idx,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          cfg1_q,
    output logic [DW-1:0]          cfg2_q,
    output logic [3:0]             buf_sel,
    output logic [2:0]             sec_count,
    output logic [NUM_ADDR*DW-1:0] addr_flat
);

    logic [2:0] count_dec;

    // Decode the sector-count field, zero standing for four
    always_comb begin
        count_dec = (wdata[1:0] == 2'd0) ? 3'd4 : {1'b0, wdata[1:0]};
    end

    // Configuration and start-buffer storage
    always_ff @(posedge clk) begin
        if (!rst_n || hot_rst) begin
            cfg1_q    <= CFG1_INIT;
            cfg2_q    <= '0;
            buf_sel   <= '0;
            sec_count <= 3'd1;
        end else begin
            if (cfg1_wr)
                cfg1_q <= wdata;
            if (cfg2_wr)
                cfg2_q <= wdata;
            if (sbuf_wr) begin
                buf_sel   <= wdata[11:8];
                sec_count <= count_dec;
            end
        end
    end

    // One storage word per start-address register
    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_addr
        // Hold start-address word i
        always_ff @(posedge clk) begin
            if (!rst_n || hot_rst)
                addr_flat[i*DW +: DW] <= '0;
            else if (addr_wr && addr_idx == AIDX_W'(i))
                addr_flat[i*DW +: DW] <= wdata;
        end
    end

    // Count field of zero reads as four sectors (R11)
    p_zero_is_four_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sbuf_wr && !hot_rst && wdata[1:0] == 2'd0) |=> (sec_count == 3'd4));

    // Sector count never leaves 1..4 (R11)
    p_count_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_count >= 3'd1 && sec_count <= 3'd4));

endmodule

// File: rtl/flcr_regblock.sv
// Top of the flash command/interrupt register block.
// Decodes host register writes, muxes read data, and drives the interrupt
// and ready pins from the stored configuration and interrupt state.
// Assumes one host access per cycle; reads are combinational.
module flcr_regblock
    import flcr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_ADDR = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [15:0]            host_wdata,
    output logic [15:0]            host_rdata,
    output logic                   cmd_go,
    output logic [7:0]             cmd_code,
    output logic [3:0]             buf_sel,
    output logic [2:0]             sec_count,
    output logic [NUM_ADDR*16-1:0] start_addr_flat,
    input  logic                   done_valid,
    input  logic [1:0]             done_kind,
    input  logic                   done_err,
    output logic                   irq,
    output logic                   rdy
);

    localparam int AIDX_W = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1;

    logic [DW-1:0]     cmd_q, cfg1_q, cfg2_q, int_q, stat_q;
    logic              cmd_bad, hot_rst;
    logic              sel_cmd, sel_cfg1, sel_cfg2, sel_sbuf, sel_int, sel_stat, sel_addr;
    logic [ADDR_W-1:0] addr_off;
    logic [AIDX_W-1:0] addr_idx;

    // Address decode shared by reads and writes
    always_comb begin
        sel_cmd  = host_addr == ADDR_W'(OFF_CMD);
        sel_cfg1 = host_addr == ADDR_W'(OFF_CFG1);
        sel_cfg2 = host_addr == ADDR_W'(OFF_CFG2);
        sel_sbuf = host_addr == ADDR_W'(OFF_SBUF);
        sel_stat = host_addr == ADDR_W'(OFF_STAT);
        sel_int  = host_addr == ADDR_W'(OFF_INT);
        addr_off = host_addr - ADDR_W'(OFF_ADDR0);
        sel_addr = (host_addr >= ADDR_W'(OFF_ADDR0)) && (addr_off < ADDR_W'(NUM_ADDR));
        addr_idx = addr_off[AIDX_W-1:0];
    end

    flcr_cmd_unit u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (host_wr && sel_cmd),
        .wdata       (host_wdata),
        .int_pending (int_q[INT_SUM]),
        .cmd_q       (cmd_q),
        .cmd_go      (cmd_go),
        .cmd_code    (cmd_code),
        .cmd_bad     (cmd_bad),
        .hot_rst     (hot_rst)
    );

    flcr_int_unit u_int (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_wr     (host_wr && sel_int),
        .wdata      (host_wdata),
        .done_valid (done_valid),
        .done_kind  (done_kind),
        .done_err   (done_err),
        .cmd_bad    (cmd_bad),
        .hot_rst    (hot_rst),
        .int_q      (int_q),
        .stat_q     (stat_q)
    );

    flcr_cfg_unit #(.NUM_ADDR(NUM_ADDR)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hot_rst   (hot_rst),
        .cfg1_wr   (host_wr && sel_cfg1),
        .cfg2_wr   (host_wr && sel_cfg2),
        .sbuf_wr   (host_wr && sel_sbuf),
        .addr_wr   (host_wr && sel_addr),
        .addr_idx  (addr_idx),
        .wdata     (host_wdata),
        .cfg1_q    (cfg1_q),
        .cfg2_q    (cfg2_q),
        .buf_sel   (buf_sel),
        .sec_count (sec_count),
        .addr_flat (start_addr_flat)
    );

    // Read-data multiplexer
    always_comb begin
        host_rdata = '0;
        if (sel_cmd)       host_rdata = cmd_q;
        else if (sel_cfg1) host_rdata = {cfg1_q[15:5], 5'b0};
        else if (sel_cfg2) host_rdata = cfg2_q;
        else if (sel_sbuf) host_rdata = {4'b0, buf_sel, 6'b0, sec_count[1:0]};
        else if (sel_stat) host_rdata = stat_q;
        else if (sel_int)  host_rdata = int_q;
        else if (sel_addr) host_rdata = start_addr_flat[int'(addr_idx)*DW +: DW];
    end

    // Pin drive from configuration and summary bit
    always_comb begin
        irq = int_q[INT_SUM] ^ ~cfg1_q[6];
        rdy = cfg1_q[7];
    end

    // A hot reset leaves the reset-done flag and summary bit set (R12)
    p_hot_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hot_rst |=> (int_q == INT_HOT_INIT && !cmd_go));

endmodule

// File: tb/flcr_regblock_test.sv
// Directed bench for flcr_regblock: one task per scenario.
module flcr_regblock_test;

    localparam int NA = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          cmd_go;
    logic [7:0]    cmd_code;
    logic [3:0]    buf_sel;
    logic [2:0]    sec_count;
    logic [NA*16-1:0] start_addr_flat;
    logic          done_valid = 1'b0;
    logic [1:0]    done_kind = '0;
    logic          done_err = 1'b0;
    logic          irq, rdy;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    flcr_regblock #(.ADDR_W(8), .NUM_ADDR(NA)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_go(cmd_go),
        .cmd_code(cmd_code), .buf_sel(buf_sel), .sec_count(sec_count),
        .start_addr_flat(start_addr_flat), .done_valid(done_valid),
        .done_kind(done_kind), .done_err(done_err), .irq(irq), .rdy(rdy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        host_addr = a;
        #1;
        chk(req, host_rdata, exp);
    endtask

    task automatic done(input logic [1:0] k, input logic e);
        @(negedge clk);
        done_valid = 1'b1; done_kind = k; done_err = e;
        @(negedge clk);
        done_valid = 1'b0; done_err = 1'b0;
    endtask

    task automatic t_reset_state();
        rd_chk("R1 cfg1", 8'h01, 16'h40C0);
        rd_chk("R1 cfg2", 8'h02, 16'h0000);
        rd_chk("R1 int",  8'h05, 16'h8080);
        rd_chk("R1 stat", 8'h04, 16'h0000);
        rd_chk("R1 cmd",  8'h00, 16'h0000);
        rd_chk("R1 sbuf", 8'h03, 16'h0001);
        rd_chk("R1 addr", 8'h13, 16'h0000);
        chk("R9 irq reset", 16'(irq), 16'h1);
        chk("R9 rdy reset", 16'(rdy), 16'h1);
    endtask

    task automatic t_refused();
        wr(8'h00, 16'h0080);
        chk("R3 no strobe", 16'(cmd_go), 16'h0);
        rd_chk("R3 cmd kept", 8'h00, 16'h0000);
        rd_chk("R3 int kept", 8'h05, 16'h8080);
    endtask

    task automatic t_clear_all();
        wr(8'h05, 16'h0000);
        rd_chk("R7 int cleared", 8'h05, 16'h0000);
        chk("R9 irq low", 16'(irq), 16'h0);
    endtask

    task automatic t_accept_and_load();
        wr(8'h00, 16'h0013);
        chk("R2 strobe", 16'(cmd_go), 16'h1);
        chk("R2 code", 16'(cmd_code), 16'h0013);
        rd_chk("R2 cmd reg", 8'h00, 16'h0013);
        @(negedge clk);
        chk("R2 one cycle", 16'(cmd_go), 16'h0);
        done(2'd3, 1'b0);
        rd_chk("R5 load done", 8'h05, 16'h8080);
        rd_chk("R6 no error", 8'h04, 16'h0000);
        chk("R9 irq high", 16'(irq), 16'h1);
    endtask

    task automatic t_prog_error_and_mask();
        wr(8'h05, 16'h0000);
        wr(8'h00, 16'h0080);
        chk("R2 prog strobe", 16'(cmd_go), 16'h1);
        done(2'd2, 1'b1);
        rd_chk("R6 prog err", 8'h04, 16'h1400);
        rd_chk("R5 prog done", 8'h05, 16'h8040);
        wr(8'h05, 16'hFFBF);
        rd_chk("R7 partial mask", 8'h05, 16'h8000);
        rd_chk("R7 errs kept", 8'h04, 16'h1400);
        wr(8'h05, 16'h0000);
        rd_chk("R7 errs cleared", 8'h04, 16'h0000);
    endtask

    task automatic t_unknown();
        wr(8'h00, 16'h0055);
        chk("R4 no strobe", 16'(cmd_go), 16'h0);
        rd_chk("R4 stat", 8'h04, 16'h0400);
        rd_chk("R4 int", 8'h05, 16'h8000);
    endtask

    task automatic t_priority();
        @(negedge clk);
        host_wr = 1'b1; host_addr = 8'h05; host_wdata = 16'h0000;
        done_valid = 1'b1; done_kind = 2'd1; done_err = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; done_valid = 1'b0; done_err = 1'b0;
        rd_chk("R8 int", 8'h05, 16'h8020);
        rd_chk("R8 stat", 8'h04, 16'h0C00);
        wr(8'h05, 16'h0000);
        done(2'd0, 1'b1);
        rd_chk("R5 reset done", 8'h05, 16'h8010);
        rd_chk("R6 reset err", 8'h04, 16'h0400);
        wr(8'h05, 16'h0000);
    endtask

    task automatic t_config();
        wr(8'h01, 16'h0000);
        chk("R9 irq inverted", 16'(irq), 16'h1);
        chk("R9 rdy low", 16'(rdy), 16'h0);
        wr(8'h01, 16'h40DF);
        rd_chk("R10 cfg1 low bits", 8'h01, 16'h40C0);
        chk("R9 irq normal", 16'(irq), 16'h0);
        chk("R9 rdy high", 16'(rdy), 16'h1);
        wr(8'h02, 16'hBEEF);
        rd_chk("R10 cfg2", 8'h02, 16'hBEEF);
    endtask

    task automatic t_startbuf();
        wr(8'h03, 16'hFA02);
        chk("R11 buf_sel", 16'(buf_sel), 16'h000A);
        chk("R11 count 2", 16'(sec_count), 16'h0002);
        rd_chk("R11 read", 8'h03, 16'h0A02);
        wr(8'h03, 16'h0300);
        chk("R11 count 4", 16'(sec_count), 16'h0004);
        rd_chk("R11 read zero", 8'h03, 16'h0300);
    endtask

    task automatic t_addr();
        wr(8'h15, 16'hA5C3);
        wr(8'h10, 16'h1234);
        rd_chk("R13 addr5", 8'h15, 16'hA5C3);
        rd_chk("R13 addr0", 8'h10, 16'h1234);
        chk("R13 flat5", start_addr_flat[5*16 +: 16], 16'hA5C3);
        rd_chk("R13 addr6", 8'h16, 16'h0000);
    endtask

    task automatic t_hot_reset();
        wr(8'h00, 16'h00F3);
        chk("R12 no strobe", 16'(cmd_go), 16'h0);
        rd_chk("R12 int", 8'h05, 16'h8010);
        rd_chk("R12 cfg2", 8'h02, 16'h0000);
        rd_chk("R12 sbuf", 8'h03, 16'h0001);
        rd_chk("R12 addr", 8'h15, 16'h0000);
        rd_chk("R12 cmd", 8'h00, 16'h00F3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_refused();
        t_clear_all();
        t_accept_and_load();
        t_prog_error_and_mask();
        t_unknown();
        t_priority();
        t_config();
        t_startbuf();
        t_addr();
        t_hot_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule